// File: doc/BRIEF.md
# Two-Class Interrupt Status Controller

This block takes a vector of one-cycle event strobes and sorts each event into two interrupt classes. A host programs two enable registers. The first enable register routes events to the high-priority class. The second routes them to the standard class. Each enabled high-priority event sets its own cause bit in a status register that the host clears by writing ones (write-one-to-clear). Any enabled standard event sets one shared standard summary bit, which sits in the same status register.

The block drives three registered interrupt outputs:
- A standard level, which follows the summary bit.
- A standard pulse, which fires once for every enabled standard event. When several events arrive together, the pulses come out on consecutive cycles from a pending counter.
- A high-priority level, which is the OR of the set cause bits. It also includes the summary bit when that bit's own high-priority enable is set.

The host accesses the block through a plain address / write-enable / data port, with read data registered one cycle after the address.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0 and all three outputs are low.
- R2: Register map:
  - Address 0 holds the high-priority enables. Bits [N-1:0] route events, and bit N routes the summary bit.
  - Address 1 holds the standard enables in bits [N-1:0].
  - Address 2 is the status register. Bits [N-1:0] are cause bits, and bit N is the standard summary.
  - Address 3 reads 0.
  - A write takes effect at the clock edge. Read data for an address appears one cycle after the address is presented.
- R3: An event i whose high-priority enable bit i is 1 sets status bit i, and the high-priority output is high one cycle after the strobe.
- R4: An event whose standard enable bit is 1 sets the summary bit (status bit N), and the standard level output is high one cycle after the strobe.
- R5: Writing status with a 1 in a bit position clears that bit. A 0 in a bit position leaves that bit unchanged.
- R6: An event that sets a status bit in the same cycle as a write that clears that bit wins, so the bit stays set.
- R7: Each enabled standard event yields exactly one one-clock pulse. Pulses from events in the same or nearby cycles come out back to back, starting one cycle after the first strobe.
- R8: The high-priority output equals the OR of the set cause bits, ORed with the summary bit only when high-priority enable bit N is 1.
- R9: An event whose enable bit is 0 in both enable registers changes no status bit and produces no pulse.
- R10: The standard level and high-priority outputs drop one cycle after the write that clears the last bit driving them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_EVT | One-cycle event strobes |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | NUM_EVT+1 | Register write data |
| reg_rdata_o | output | NUM_EVT+1 | Registered read data |
| std_lvl_o | output | 1 | Standard interrupt level |
| std_pulse_o | output | 1 | Standard interrupt pulse, one per enabled event |
| hp_irq_o | output | 1 | High-priority interrupt level |

## Verification
All results have a latency of one clock:
- Status bits and both level outputs change on the edge that samples a strobe or a clearing write.
- The first pulse of a group appears on the edge that samples the strobe.
- Read data follows its address by one edge.

The bench drives inputs just after a falling edge and samples just after the next falling edge, so every check lands exactly one rising edge after its stimulus. Pulses are gathered over a fixed window after the strobe and compared as a contiguous run of the expected length. The near-exhaustive sweep covers every enable and event combination of a four-event configuration.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;

  typedef enum logic [1:0] {
    REG_HP_EN  = 2'd0,
    REG_STD_EN = 2'd1,
    REG_STATUS = 2'd2,
    REG_SPARE  = 2'd3
  } irq_reg_e;

  function automatic int unsigned pend_limit(input int unsigned w);
    return (1 << w) - 1;
  endfunction

endpackage

// File: rtl/dual_irq_cfg.sv
module dual_irq_cfg #(
  parameter int NUM_EVT = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 we_i,
  input  dual_irq_pkg::irq_reg_e addr_i,
  input  logic [NUM_EVT:0]     wdata_i,
  output logic [NUM_EVT:0]     hp_en_o,
  output logic [NUM_EVT-1:0]   std_en_o
);
  import dual_irq_pkg::*;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hp_en_o  <= '0;
      std_en_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_HP_EN:  hp_en_o  <= wdata_i;
        REG_STD_EN: std_en_o <= wdata_i[NUM_EVT-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dual_irq_status.sv
module dual_irq_status #(
  parameter int NUM_EVT = 16
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT:0]   hp_en_i,
  input  logic [NUM_EVT-1:0] std_en_i,
  input  logic               clr_we_i,
  input  logic [NUM_EVT:0]   clr_mask_i,
  output logic [NUM_EVT:0]   status_o,
  output logic               hp_irq_o,
  output logic               std_lvl_o
);
  localparam int SUM = NUM_EVT;

  logic [NUM_EVT:0] set_w;
  logic [NUM_EVT:0] clr_w;
  logic [NUM_EVT:0] next_w;
  logic             hp_next_w;

  always_comb begin
    set_w[NUM_EVT-1:0] = evt_i & hp_en_i[NUM_EVT-1:0];
    set_w[SUM]         = |(evt_i & std_en_i);
    clr_w              = clr_we_i ? clr_mask_i : '0;
    // a set in the same cycle overrides the clear
    next_w             = (status_o & ~clr_w) | set_w;
    hp_next_w          = (|next_w[NUM_EVT-1:0]) | (next_w[SUM] & hp_en_i[SUM]);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      status_o  <= '0;
      hp_irq_o  <= 1'b0;
      std_lvl_o <= 1'b0;
    end else begin
      status_o  <= next_w;
      hp_irq_o  <= hp_next_w;
      std_lvl_o <= next_w[SUM];
    end
  end
endmodule

// File: rtl/dual_irq_pulse.sv
module dual_irq_pulse #(
  parameter int NUM_EVT = 16,
  parameter int PEND_W  = 6
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_EVT-1:0] hits_i,
  output logic               pulse_o
);
  localparam int ADD_W = $clog2(NUM_EVT + 1);
  localparam int SUM_W = ((PEND_W + 1) > (ADD_W + 1)) ? (PEND_W + 1) : (ADD_W + 1);
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(dual_irq_pkg::pend_limit(PEND_W));

  logic [PEND_W-1:0] pend_q;
  logic [ADD_W-1:0]  add_w;
  logic [SUM_W-1:0]  sum_w;
  logic [SUM_W-1:0]  sat_w;
  logic              fire_w;
  logic [SUM_W-1:0]  rest_w;

  always_comb begin
    add_w  = ADD_W'($countones(hits_i));
    sum_w  = SUM_W'(pend_q) + SUM_W'(add_w);
    sat_w  = (sum_w > LIMIT) ? LIMIT : sum_w;
    fire_w = (sat_w != '0);
    rest_w = sat_w - SUM_W'(fire_w);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q  <= '0;
      pulse_o <= 1'b0;
    end else begin
      pend_q  <= rest_w[PEND_W-1:0];
      pulse_o <= fire_w;
    end
  end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
  parameter int NUM_EVT = 16,
  parameter int PEND_W  = 6
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [NUM_EVT:0]   reg_wdata_i,
  output logic [NUM_EVT:0]   reg_rdata_o,
  output logic               std_lvl_o,
  output logic               std_pulse_o,
  output logic               hp_irq_o
);
  import dual_irq_pkg::*;

  irq_reg_e           addr_w;
  logic [NUM_EVT:0]   hp_en_q;
  logic [NUM_EVT-1:0] std_en_q;
  logic [NUM_EVT:0]   status_q;
  logic               clr_we_w;

  assign addr_w   = irq_reg_e'(reg_addr_i);
  assign clr_we_w = reg_we_i && (addr_w == REG_STATUS);

  dual_irq_cfg #(.NUM_EVT(NUM_EVT)) u_cfg (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .we_i     (reg_we_i),
    .addr_i   (addr_w),
    .wdata_i  (reg_wdata_i),
    .hp_en_o  (hp_en_q),
    .std_en_o (std_en_q)
  );

  dual_irq_status #(.NUM_EVT(NUM_EVT)) u_status (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .evt_i      (evt_i),
    .hp_en_i    (hp_en_q),
    .std_en_i   (std_en_q),
    .clr_we_i   (clr_we_w),
    .clr_mask_i (reg_wdata_i),
    .status_o   (status_q),
    .hp_irq_o   (hp_irq_o),
    .std_lvl_o  (std_lvl_o)
  );

  dual_irq_pulse #(.NUM_EVT(NUM_EVT), .PEND_W(PEND_W)) u_pulse (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .hits_i  (evt_i & std_en_q),
    .pulse_o (std_pulse_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      reg_rdata_o <= '0;
    end else begin
      case (addr_w)
        REG_HP_EN:  reg_rdata_o <= hp_en_q;
        REG_STD_EN: reg_rdata_o <= {1'b0, std_en_q};
        REG_STATUS: reg_rdata_o <= status_q;
        default:    reg_rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_irq_checker.sv
module dual_irq_checker #(
  parameter int NUM_EVT = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_EVT-1:0] evt,
  input logic               we,
  input logic [1:0]         addr,
  input logic [NUM_EVT:0]   wdata,
  input logic [NUM_EVT:0]   hp_en,
  input logic [NUM_EVT-1:0] std_en,
  input logic [NUM_EVT:0]   status,
  input logic               hp_irq,
  input logic               std_lvl
);

  a_r3_cause_sets: assert property (@(posedge clk) disable iff (rst)
    (|(evt & hp_en[NUM_EVT-1:0])) |=>
      (((status[NUM_EVT-1:0] & $past(evt & hp_en[NUM_EVT-1:0])) ==
        $past(evt & hp_en[NUM_EVT-1:0])) && hp_irq));

  a_r4_std_level: assert property (@(posedge clk) disable iff (rst)
    (|(evt & std_en)) |=> (std_lvl && status[NUM_EVT]));

  a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 2'd2 && evt == '0) |=> ((status & $past(wdata)) == '0));

  a_r8_hp_level: assert property (@(posedge clk) disable iff (rst)
    hp_irq == ((|status[NUM_EVT-1:0]) || (status[NUM_EVT] && $past(hp_en[NUM_EVT]))));

  a_r9_ignored: assert property (@(posedge clk) disable iff (rst)
    (!we && (evt & (hp_en[NUM_EVT-1:0] | std_en)) == '0) |=> $stable(status));

endmodule

bind dual_irq_ctrl dual_irq_checker #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk     (clk_i),
  .rst     (rst_i),
  .evt     (evt_i),
  .we      (reg_we_i),
  .addr    (reg_addr_i),
  .wdata   (reg_wdata_i),
  .hp_en   (hp_en_q),
  .std_en  (std_en_q),
  .status  (status_q),
  .hp_irq  (hp_irq_o),
  .std_lvl (std_lvl_o)
);

// File: tb/dual_irq_ctrl_test.sv
`timescale 1ns/1ps
module dual_irq_ctrl_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] evt = '0;
  logic         we = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [N:0]   wdata = '0;
  logic [N:0]   rdata;
  logic         std_lvl, std_pulse, hp_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dual_irq_ctrl #(.NUM_EVT(N), .PEND_W(5)) uut (
    .clk_i(clk), .rst_i(rst), .evt_i(evt), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .std_lvl_o(std_lvl),
    .std_pulse_o(std_pulse), .hp_irq_o(hp_irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [N:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output int d);
    addr = a;
    tick();
    d = int'(rdata);
  endtask

  // count pulses over w samples; run = 1 if they form one run starting at sample 0
  task automatic collect(int w, output int cnt, output int run);
    bit seen_zero;
    cnt = 0; run = 1; seen_zero = 0;
    for (int i = 0; i < w; i++) begin
      if (std_pulse) begin
        cnt++;
        if (seen_zero) run = 0;
      end else begin
        seen_zero = 1;
      end
      tick();
    end
  endtask

  initial begin
    int d, cnt, run, exp_st, exp_hp, cause, sum;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    check("R1 hp_irq", hp_irq, 0);
    check("R1 std_lvl", std_lvl, 0);
    check("R1 std_pulse", std_pulse, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reg reset", d, 0);
    end

    // R2 enable read back
    wr(2'd0, 5'h1A);
    wr(2'd1, 5'h1F);
    rd(2'd0, d); check("R2 hp_en readback", d, 'h1A);
    rd(2'd1, d); check("R2 std_en readback", d, 'h0F);
    rd(2'd3, d); check("R2 spare reads zero", d, 0);

    // R5 write-one-to-clear
    wr(2'd0, 5'h0F); wr(2'd1, 5'h00);
    evt = 4'hF; tick(); evt = '0;
    rd(2'd2, d); check("R3 all causes", d, 'h0F);
    wr(2'd2, 5'h05);
    rd(2'd2, d); check("R5 partial clear", d, 'h0A);
    check("R5 hp_irq held", hp_irq, 1);
    wr(2'd2, 5'h00);
    rd(2'd2, d); check("R5 zero write no effect", d, 'h0A);
    wr(2'd2, 5'h0A);
    check("R10 hp_irq drops", hp_irq, 0);
    rd(2'd2, d); check("R5 full clear", d, 0);

    // R6 event beats clear
    wr(2'd0, 5'h01); wr(2'd1, 5'h01);
    evt = 4'h1; tick(); evt = '0;
    collect(3, cnt, run);
    we = 1'b1; addr = 2'd2; wdata = 5'h1F; evt = 4'h1;
    tick();
    we = 1'b0; wdata = '0; evt = '0;
    check("R6 std_lvl kept", std_lvl, 1);
    check("R6 hp_irq kept", hp_irq, 1);
    collect(3, cnt, run);
    check("R7 pulse on collision event", cnt, 1);
    rd(2'd2, d); check("R6 status kept", d, 'h11);
    wr(2'd2, 5'h1F);
    check("R10 std_lvl drops", std_lvl, 0);

    // R7 burst: 3 cycles of 4 events -> 12 contiguous pulses
    wr(2'd0, 5'h00); wr(2'd1, 5'h0F);
    evt = 4'hF; tick(); tick(); tick(); evt = '0;
    // first pulse began after first event edge; two ticks since then consumed
    cnt = 2; run = 1;
    begin
      int c2, r2;
      collect(14, c2, r2);
      check("R7 burst count", cnt + c2, 12);
      check("R7 burst contiguous", r2, 1);
    end
    wr(2'd2, 5'h1F);

    // sweep: every hp enable, std enable and event pattern
    for (int h = 0; h < 32; h++) begin
      for (int s = 0; s < 16; s++) begin
        for (int e = 0; e < 16; e++) begin
          wr(2'd0, 5'(h));
          wr(2'd1, 5'(s));
          wr(2'd2, 5'h1F);
          check("R10 cleared outputs", {hp_irq, std_lvl}, 0);
          cause  = e & h & 'hF;
          sum    = ((e & s) != 0) ? 1 : 0;
          exp_st = (sum << N) | cause;
          exp_hp = (cause != 0 || (sum != 0 && ((h >> N) & 1) != 0)) ? 1 : 0;
          evt = 4'(e);
          tick();
          evt = '0;
          check((cause != 0) ? "R3 hp_irq" : "R8 hp_irq", hp_irq, exp_hp);
          check("R4 std_lvl", std_lvl, sum);
          collect(6, cnt, run);
          check(((e & (h | s) & 'hF) == 0) ? "R9 ignored pulses" : "R7 pulse count",
                cnt, $countones(4'(e & s)));
          check("R7 pulse contiguous", run, 1);
          rd(2'd2, d);
          check(((e & (h | s) & 'hF) == 0) ? "R9 ignored status" : "R3 R4 status",
                d, exp_st);
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule